// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block runs one I2C message on its own, taking the place of the interrupt handler that would otherwise drive an I2C master core through its register file. Software or a higher-level controller gives it a 7-bit target address, a direction flag and a byte count, then pulses `start`. The sequencer programs the core's interrupt-enable and control registers to issue START. From then on it reacts to each event the core reports by making the register accesses that event calls for. It fetches outgoing bytes from a message buffer by index and writes incoming bytes back to that buffer.

It keeps a signed position counter that begins at -1 for the address byte. On a read, the receive path in the core is two stages deep, so the data returned by a data-register read belongs to the byte two positions earlier. A missing acknowledge or lost arbitration does not abort the message. The sequencer clears those flags, remembers them, and lets the core run on to STOP. Once the last event has been handled, it polls the core's BUSY flag a bounded number of times. It then presents a one-cycle `done` pulse with an error code.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset `done`, `acc_en` and `buf_we` are low. Register selects are: 0 control, 1 interrupt enable, 2 status, 3 data.
- R2: An accepted `start` produces exactly two writes: interrupt enable 0x0F, then control 0x94 (START). The event flag bits are: 0 WAIT, 1 DTE, 2 TACK, 3 AL.
- R3: The address byte is `{addr, rd}`. Except when it is also the last byte of a write, its data write is preceded by an interrupt-enable write of 0x0D, which clears the DTE enable.
- R4: A write sends byte i (read from the buffer at `buf_idx` = i) on event i+1. The byte at position len-1 is followed by a control write of 0x90. The event after that completes the write. A zero-length write sends the address with 0x90.
- R5: On a read, the event at position 0 writes control 0x81. Every later event except the one at position len does one data read. The read is stored at index position-2 only when that index is non-negative.
- R6: On a read, the event at position len writes interrupt enable 0x0F. If position-2 ≥ 0 it then does a data read that is stored. It then writes control 0xC0. The read completes after len+3 events.
- R7: A start with `rd`=1 and length 0 gives `done` one cycle later with code 3 and no register access.
- R8: An event carrying TACK or AL makes no transfer access. The position does not advance, so the next event carries on with the same byte. The error is reported as code 1 at completion.
- R9: Every event with WAIT, TACK or AL set ends with a status write in which WAIT, TACK and AL are zero. This write comes after the event's other accesses.
- R10: After completion BUSY is sampled in the next cycle, then every POLL_GAP cycles, for up to POLL_TRIES samples. A clear sample gives `done` in the following cycle. If BUSY never clears, `done` carries code 2, which takes priority over code 1.
- R11: `done` is a single-cycle pulse. Code 0 means a clean transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a message (taken only when idle) |
| msg_addr | input | 7 | Target address |
| msg_rd | input | 1 | 1 = read message |
| msg_len | input | LEN_W | Byte count |
| evt | input | 1 | Core event strobe |
| evt_status | input | 4 | Core status flags for the event |
| acc_en | output | 1 | Register access strobe |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_sel | output | 2 | Register select |
| acc_wdata | output | 8 | Write data |
| acc_rdata | input | 8 | Read data, valid in the access cycle |
| buf_idx | output | LEN_W | Transmit buffer index |
| buf_rdata | input | 8 | Transmit byte at `buf_idx` |
| buf_we | output | 1 | Receive buffer write strobe |
| buf_widx | output | LEN_W | Receive buffer index |
| buf_wdata | output | 8 | Receive byte |
| bus_busy | input | 1 | Core BUSY flag |
| done | output | 1 | Completion pulse |
| err_code | output | 2 | 0 ok, 1 no-ack/arbitration, 2 busy timeout, 3 bad length |

## Verification
The assertions assume that `evt` is presented only while the sequencer is waiting for an event. They also assume that the status flags follow the core's meaning, so that error bits arrive only on a real fault. The stimulus keeps to this by leaving several idle cycles after each event, which is more than the longest access sequence of three accesses plus a status write. It also holds `acc_rdata`, `buf_rdata` and `bus_busy` stable for as long as the sequencer may sample them.

// File: rtl/i2c_msg_seq_pkg.sv
package i2c_msg_seq_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_IEN  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    localparam int FLG_WAIT = 0;
    localparam int FLG_DTE  = 1;
    localparam int FLG_TACK = 2;
    localparam int FLG_AL   = 3;

    // command bytes decoded by the master core
    localparam logic [7:0] CMD_START   = 8'h94;
    localparam logic [7:0] CMD_TX_STOP = 8'h90;
    localparam logic [7:0] CMD_TO_RX   = 8'h81;
    localparam logic [7:0] CMD_RX_STOP = 8'hC0;

    localparam logic [7:0] IEN_ALL    = 8'h0F;
    localparam logic [7:0] IEN_NO_DTE = 8'h0D;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADDR,
        OP_DATA,
        OP_DATA_STOP,
        OP_TO_RX,
        OP_RD,
        OP_RD_STOP,
        OP_RD_STOP_DATA
    } op_e;

    typedef enum logic [1:0] {
        ERR_OK   = 2'd0,
        ERR_BUS  = 2'd1,
        ERR_BUSY = 2'd2,
        ERR_LEN  = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_IEN,
        ST_SET_START,
        ST_WAIT_EVT,
        ST_EXEC,
        ST_CLR,
        ST_POLL,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic       en;
        logic       wr;
        reg_sel_e   sel;
        logic [7:0] wdata;
    } acc_t;

endpackage

// File: rtl/i2c_msg_seq_ops.sv
// Micro-step table: which register access belongs to step n of an operation.
module i2c_msg_seq_ops
    import i2c_msg_seq_pkg::*;
(
    input  op_e        op,
    input  logic [1:0] step,
    input  logic [7:0] byte_i,
    output acc_t       acc,
    output logic       last
);
    always_comb begin
        acc  = '{en: 1'b1, wr: 1'b1, sel: SEL_DATA, wdata: byte_i};
        last = 1'b1;
        case (op)
            OP_ADDR: begin
                if (step == 2'd0) begin
                    acc.sel   = SEL_IEN;
                    acc.wdata = IEN_NO_DTE;
                    last      = 1'b0;
                end
            end
            OP_DATA: ;
            OP_DATA_STOP: begin
                if (step == 2'd0) begin
                    last = 1'b0;
                end else begin
                    acc.sel   = SEL_CTRL;
                    acc.wdata = CMD_TX_STOP;
                end
            end
            OP_TO_RX: begin
                acc.sel   = SEL_CTRL;
                acc.wdata = CMD_TO_RX;
            end
            OP_RD: begin
                acc.wr    = 1'b0;
                acc.wdata = 8'h00;
            end
            OP_RD_STOP: begin
                if (step == 2'd0) begin
                    acc.sel   = SEL_IEN;
                    acc.wdata = IEN_ALL;
                    last      = 1'b0;
                end else begin
                    acc.sel   = SEL_CTRL;
                    acc.wdata = CMD_RX_STOP;
                end
            end
            OP_RD_STOP_DATA: begin
                case (step)
                    2'd0: begin
                        acc.sel   = SEL_IEN;
                        acc.wdata = IEN_ALL;
                        last      = 1'b0;
                    end
                    2'd1: begin
                        acc.wr    = 1'b0;
                        acc.wdata = 8'h00;
                        last      = 1'b0;
                    end
                    default: begin
                        acc.sel   = SEL_CTRL;
                        acc.wdata = CMD_RX_STOP;
                    end
                endcase
            end
            default: begin
                acc.en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/i2c_msg_seq_poll.sv
// Bounded BUSY poll: first sample on entry, then one every GAP cycles.
module i2c_msg_seq_poll #(
    parameter int TRIES = 1000,
    parameter int GAP   = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic busy,
    output logic ok,
    output logic tmo
);
    localparam int TW = (TRIES > 1) ? $clog2(TRIES) : 1;
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [TW-1:0] TRY_LAST = TW'(TRIES - 1);
    localparam logic [GW-1:0] GAP_LOAD = GW'(GAP - 1);

    typedef struct packed {
        logic [TW-1:0] tries;
        logic [GW-1:0] gap;
    } poll_t;

    poll_t q, d;
    logic  sample;

    always_comb begin
        d      = q;
        sample = en && (q.gap == '0);
        ok     = sample && !busy;
        tmo    = sample && busy && (q.tries == TRY_LAST);
        if (!en) begin
            d = '0;
        end else if (sample) begin
            d.tries = q.tries + 1'b1;
            d.gap   = GAP_LOAD;
        end else begin
            d.gap = q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2c_msg_seq_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int POLL_TRIES = 1000,
    parameter int POLL_GAP   = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [6:0]       msg_addr,
    input  logic             msg_rd,
    input  logic [LEN_W-1:0] msg_len,
    input  logic             evt,
    input  logic [3:0]       evt_status,
    output logic             acc_en,
    output logic             acc_wr,
    output logic [1:0]       acc_sel,
    output logic [7:0]       acc_wdata,
    input  logic [7:0]       acc_rdata,
    output logic [LEN_W-1:0] buf_idx,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [LEN_W-1:0] buf_widx,
    output logic [7:0]       buf_wdata,
    input  logic             bus_busy,
    output logic             done,
    output err_e             err_code
);
    localparam int PW = LEN_W + 2;
    localparam logic signed [PW-1:0] P_ONE = PW'(1);
    localparam logic signed [PW-1:0] P_TWO = PW'(2);
    localparam logic signed [PW-1:0] P_ADR = -P_ONE;

    typedef struct packed {
        st_e                     st;
        logic signed [PW-1:0]    pos;
        logic [LEN_W-1:0]        len;
        logic                    rd;
        logic [6:0]              addr;
        logic [1:0]              step;
        op_e                     op;
        logic [3:0]              sr;
        logic [7:0]              tx_byte;
        logic                    store;
        logic [LEN_W-1:0]        sidx;
        logic                    bus_err;
        logic                    last;
        err_e                    err;
    } seq_t;

    seq_t q, d;

    acc_t ops_acc;
    logic ops_last;
    logic poll_ok, poll_tmo;
    logic idle_w;
    acc_t acc;

    i2c_msg_seq_ops u_ops (
        .op     (q.op),
        .step   (q.step),
        .byte_i (q.tx_byte),
        .acc    (ops_acc),
        .last   (ops_last)
    );

    i2c_msg_seq_poll #(
        .TRIES (POLL_TRIES),
        .GAP   (POLL_GAP)
    ) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.st == ST_POLL),
        .busy  (bus_busy),
        .ok    (poll_ok),
        .tmo   (poll_tmo)
    );

    function automatic st_e after_ops(input logic [3:0] sr, input logic last);
        if (sr[FLG_WAIT] || sr[FLG_TACK] || sr[FLG_AL]) return ST_CLR;
        else if (last)                                return ST_POLL;
        else                                          return ST_WAIT_EVT;
    endfunction

    always_comb begin
        logic signed [PW-1:0] lenx;
        logic signed [PW-1:0] nxt;
        logic signed [PW-1:0] rel;
        d      = q;
        acc    = '{en: 1'b0, wr: 1'b0, sel: SEL_CTRL, wdata: 8'h00};
        buf_we = 1'b0;
        lenx   = $signed({2'b00, q.len});
        nxt    = q.pos + P_ONE;
        rel    = q.pos - P_TWO;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.addr    = msg_addr;
                    d.rd      = msg_rd;
                    d.len     = msg_len;
                    d.pos     = P_ADR;
                    d.bus_err = 1'b0;
                    d.op      = OP_NONE;
                    if (msg_rd && msg_len == '0) begin
                        d.err = ERR_LEN;
                        d.st  = ST_DONE;
                    end else begin
                        d.st = ST_SET_IEN;
                    end
                end
            end
            ST_SET_IEN: begin
                acc  = '{en: 1'b1, wr: 1'b1, sel: SEL_IEN, wdata: IEN_ALL};
                d.st = ST_SET_START;
            end
            ST_SET_START: begin
                acc  = '{en: 1'b1, wr: 1'b1, sel: SEL_CTRL, wdata: CMD_START};
                d.st = ST_WAIT_EVT;
            end
            ST_WAIT_EVT: begin
                if (evt) begin
                    d.sr      = evt_status;
                    d.step    = 2'd0;
                    d.store   = 1'b0;
                    d.sidx    = rel[LEN_W-1:0];
                    d.tx_byte = (q.pos < 0) ? {q.addr, q.rd} : buf_rdata;
                    d.last    = 1'b0;
                    if (evt_status[FLG_TACK] || evt_status[FLG_AL]) begin
                        d.bus_err = 1'b1;
                        d.op      = OP_NONE;
                    end else if (q.rd) begin
                        if (q.pos < 0)       d.op = OP_ADDR;
                        else if (q.pos == 0) d.op = OP_TO_RX;
                        else if (q.pos == lenx)
                            d.op = (rel < 0) ? OP_RD_STOP : OP_RD_STOP_DATA;
                        else
                            d.op = OP_RD;
                        d.store = (q.pos > 0) && (rel >= 0);
                        d.pos   = nxt;
                        d.last  = (nxt == lenx + P_TWO);
                    end else begin
                        if (q.pos == lenx) begin
                            d.op   = OP_NONE;
                            d.last = 1'b1;
                        end else begin
                            if (q.pos == lenx - P_ONE) d.op = OP_DATA_STOP;
                            else if (q.pos < 0)        d.op = OP_ADDR;
                            else                       d.op = OP_DATA;
                            d.pos = nxt;
                        end
                    end
                    if (d.op == OP_NONE) d.st = after_ops(evt_status, d.last);
                    else                 d.st = ST_EXEC;
                end
            end
            ST_EXEC: begin
                acc    = ops_acc;
                buf_we = ops_acc.en && !ops_acc.wr && q.store;
                if (ops_last) d.st = after_ops(q.sr, q.last);
                else          d.step = q.step + 2'd1;
            end
            ST_CLR: begin
                acc  = '{en: 1'b1, wr: 1'b1, sel: SEL_STAT,
                         wdata: {6'b0, q.sr[FLG_DTE], 1'b0}};
                d.st = q.last ? ST_POLL : ST_WAIT_EVT;
            end
            ST_POLL: begin
                if (poll_tmo) begin
                    d.err = ERR_BUSY;
                    d.st  = ST_DONE;
                end else if (poll_ok) begin
                    d.err = q.bus_err ? ERR_BUS : ERR_OK;
                    d.st  = ST_DONE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.op    <= OP_NONE;
            q.err   <= ERR_OK;
        end else begin
            q <= d;
        end
    end

    assign idle_w    = (q.st == ST_IDLE);
    assign acc_en    = acc.en;
    assign acc_wr    = acc.wr;
    assign acc_sel   = acc.sel;
    assign acc_wdata = acc.wdata;
    assign buf_idx   = q.pos[LEN_W-1:0];
    assign buf_widx  = q.sidx;
    assign buf_wdata = acc_rdata;
    assign done      = (q.st == ST_DONE);
    assign err_code  = q.err;

endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             msg_rd,
    input logic [LEN_W-1:0] msg_len,
    input logic             idle,
    input logic             done,
    input logic [1:0]       err_code,
    input logic             acc_en,
    input logic             acc_wr,
    input logic [1:0]       acc_sel,
    input logic [7:0]       acc_wdata,
    input logic             buf_we
);
    // R11: completion lasts one cycle
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: zero-length read rejected at once
    assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && msg_rd && msg_len == '0) |=> (done && err_code == 2'd3));

    // R5: receive stores only happen on a data-register read
    assert_store_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (acc_en && !acc_wr && acc_sel == 2'd3));

    // R9: status writes always clear WAIT, TACK and AL
    assert_stat_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_sel == 2'd2) |-> (acc_wdata[0] == 1'b0 &&
                                                   acc_wdata[2] == 1'b0 &&
                                                   acc_wdata[3] == 1'b0));

    // R2: control writes carry only the four command bytes
    assert_ctrl_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_sel == 2'd0) |->
        (acc_wdata == 8'h94 || acc_wdata == 8'h90 ||
         acc_wdata == 8'h81 || acc_wdata == 8'hC0));

    // R1: no register traffic while idle or signalling completion
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle || done) |-> !acc_en);
endmodule

bind i2c_msg_seq i2c_msg_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .msg_rd    (msg_rd),
    .msg_len   (msg_len),
    .idle      (idle_w),
    .done      (done),
    .err_code  (err_code),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .acc_wdata (acc_wdata),
    .buf_we    (buf_we)
);

// File: tb/test_i2c_msg_seq.sv
`timescale 1ns/1ps
module test_i2c_msg_seq;
    import i2c_msg_seq_pkg::*;

    localparam int LW = 8;
    localparam int TRIES = 5;
    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [6:0] msg_addr = '0;
    logic msg_rd = 1'b0;
    logic [LW-1:0] msg_len = '0;
    logic evt = 1'b0;
    logic [3:0] evt_status = '0;
    logic acc_en, acc_wr;
    logic [1:0] acc_sel;
    logic [7:0] acc_wdata;
    logic [7:0] acc_rdata = '0;
    logic [LW-1:0] buf_idx, buf_widx;
    logic [7:0] buf_rdata, buf_wdata;
    logic buf_we;
    logic bus_busy = 1'b0;
    logic done;
    err_e err_code;

    logic [7:0] txm [0:15];
    assign buf_rdata = txm[buf_idx[3:0]];

    always #2 clk = ~clk;

    i2c_msg_seq #(.LEN_W(LW), .POLL_TRIES(TRIES), .POLL_GAP(GAP)) i_i2c_msg_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .msg_addr(msg_addr),
        .msg_rd(msg_rd), .msg_len(msg_len), .evt(evt), .evt_status(evt_status),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .buf_idx(buf_idx), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
        .bus_busy(bus_busy), .done(done), .err_code(err_code)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_done = 0;
    int last_acc_cyc = 0;
    int done_cyc = 0;

    logic [10:0] q_acc [$];
    string       q_acc_tag [$];
    logic [15:0] q_st [$];
    string       q_st_tag [$];
    logic [1:0]  q_done [$];
    string       q_done_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic ok, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver side: expectation pushes
    task automatic ex_w(string tag, logic [1:0] sel, logic [7:0] d);
        q_acc.push_back({1'b1, sel, d});
        q_acc_tag.push_back(tag);
    endtask
    task automatic ex_r(string tag);
        q_acc.push_back({1'b0, 2'd3, 8'h00});
        q_acc_tag.push_back(tag);
    endtask
    task automatic ex_st(string tag, logic [7:0] idx, logic [7:0] d);
        q_st.push_back({idx, d});
        q_st_tag.push_back(tag);
    endtask
    task automatic ex_done(string tag, logic [1:0] e);
        q_done.push_back(e);
        q_done_tag.push_back(tag);
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_en) begin
                last_acc_cyc = cyc;
                if (q_acc.size() == 0) begin
                    check("R2 unexpected access", 1'b0, {5'd0, acc_wr, acc_sel, acc_wdata}, 16'hFFFF);
                end else begin
                    logic [10:0] e;
                    string t;
                    e = q_acc.pop_front();
                    t = q_acc_tag.pop_front();
                    if (e[10])
                        check(t, acc_wr && acc_sel == e[9:8] && acc_wdata == e[7:0],
                              {5'd0, acc_wr, acc_sel, acc_wdata}, {5'd0, e});
                    else
                        check(t, !acc_wr && acc_sel == e[9:8],
                              {5'd0, acc_wr, acc_sel, 8'h00}, {5'd0, e[10:8], 8'h00});
                end
            end
            if (buf_we) begin
                if (q_st.size() == 0) begin
                    check("R5 unexpected store", 1'b0, {buf_widx, buf_wdata}, 16'hFFFF);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = q_st.pop_front();
                    t = q_st_tag.pop_front();
                    check(t, {buf_widx, buf_wdata} == e, {buf_widx, buf_wdata}, e);
                end
            end
            if (done) begin
                done_cyc = cyc;
                n_done++;
                if (q_done.size() == 0) begin
                    check("R11 unexpected done", 1'b0, {14'd0, err_code}, 16'hFFFF);
                end else begin
                    logic [1:0] e;
                    string t;
                    e = q_done.pop_front();
                    t = q_done_tag.pop_front();
                    check(t, err_code == e, {14'd0, err_code}, {14'd0, e});
                end
            end
        end
    end

    task automatic go(logic [6:0] a, logic r, logic [LW-1:0] n);
        @(negedge clk);
        msg_addr = a; msg_rd = r; msg_len = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ev(logic [3:0] s, logic [7:0] rdat);
        @(negedge clk);
        evt = 1'b1; evt_status = s; acc_rdata = rdat;
        @(negedge clk);
        evt = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_done(int target);
        for (int i = 0; i < 200 && n_done < target; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic drained(string tag);
        check(tag, q_acc.size() == 0 && q_st.size() == 0 && q_done.size() == 0,
              16'(q_acc.size() + q_st.size() + q_done.size()), 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int sc;
        for (int i = 0; i < 16; i++) txm[i] = 8'h00;
        txm[0] = 8'hAA; txm[1] = 8'h55; txm[2] = 8'hC3;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", !done && !acc_en && !buf_we,
              {13'd0, done, acc_en, buf_we}, 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // zero-length write (R4, R3 exception, R10 quick poll)
        ex_w("R2 ien", 2'd1, 8'h0F); ex_w("R2 start", 2'd0, 8'h94);
        ex_w("R4 addr as last", 2'd3, 8'hA0); ex_w("R4 stop", 2'd0, 8'h90);
        ex_w("R9 wait clear", 2'd2, 8'h00);
        ex_done("R11 ok", 2'd0);
        go(7'h50, 1'b0, 8'd0);
        ev(4'h2, 8'h00);
        ev(4'h1, 8'h00);
        wait_done(1);
        check("R10 poll clear latency", done_cyc - last_acc_cyc == 2,
              16'(done_cyc - last_acc_cyc), 16'd2);
        drained("R4 zero write complete");

        // three-byte write
        ex_w("R2 ien", 2'd1, 8'h0F); ex_w("R2 start", 2'd0, 8'h94);
        ex_w("R3 dte off", 2'd1, 8'h0D); ex_w("R3 addr byte", 2'd3, 8'h56);
        ex_w("R4 byte0", 2'd3, 8'hAA); ex_w("R9 clr", 2'd2, 8'h00);
        ex_w("R4 byte1", 2'd3, 8'h55); ex_w("R9 clr keeps dte", 2'd2, 8'h02);
        ex_w("R4 byte2", 2'd3, 8'hC3); ex_w("R4 stop", 2'd0, 8'h90);
        ex_w("R9 clr", 2'd2, 8'h00);
        ex_w("R9 final clr", 2'd2, 8'h00);
        ex_done("R11 ok", 2'd0);
        go(7'h2B, 1'b0, 8'd3);
        ev(4'h2, 8'h00); ev(4'h1, 8'h00); ev(4'h3, 8'h00); ev(4'h1, 8'h00); ev(4'h1, 8'h00);
        wait_done(2);
        drained("R4 write complete");

        // one-byte read
        ex_w("R2 ien", 2'd1, 8'h0F); ex_w("R2 start", 2'd0, 8'h94);
        ex_w("R3 dte off", 2'd1, 8'h0D); ex_w("R3 read addr", 2'd3, 8'h23);
        ex_w("R5 to rx", 2'd0, 8'h81); ex_w("R9 clr", 2'd2, 8'h00);
        ex_w("R6 ien on", 2'd1, 8'h0F); ex_w("R6 rx stop", 2'd0, 8'hC0);
        ex_w("R9 clr", 2'd2, 8'h00);
        ex_r("R5 last read");
        ex_st("R5 store idx0", 8'd0, 8'h9E);
        ex_done("R6 ok", 2'd0);
        go(7'h11, 1'b1, 8'd1);
        ev(4'h2, 8'h00); ev(4'h1, 8'h00); ev(4'h1, 8'h00); ev(4'h2, 8'h9E);
        wait_done(3);
        drained("R6 one-byte read complete");

        // three-byte read
        ex_w("R2 ien", 2'd1, 8'h0F); ex_w("R2 start", 2'd0, 8'h94);
        ex_w("R3 dte off", 2'd1, 8'h0D); ex_w("R3 read addr", 2'd3, 8'hED);
        ex_w("R5 to rx", 2'd0, 8'h81); ex_w("R9 clr", 2'd2, 8'h00);
        ex_r("R5 dummy read"); ex_w("R9 clr", 2'd2, 8'h00);
        ex_r("R5 read 0"); ex_w("R9 clr", 2'd2, 8'h00);
        ex_st("R5 store idx0", 8'd0, 8'h31);
        ex_w("R6 ien on", 2'd1, 8'h0F); ex_r("R6 read 1"); ex_w("R6 rx stop", 2'd0, 8'hC0);
        ex_w("R9 clr", 2'd2, 8'h00);
        ex_st("R6 store idx1", 8'd1, 8'h42);
        ex_r("R5 read 2");
        ex_st("R5 store idx2", 8'd2, 8'h53);
        ex_done("R6 ok", 2'd0);
        go(7'h76, 1'b1, 8'd3);
        ev(4'h2, 8'h00); ev(4'h1, 8'h00); ev(4'h1, 8'hEE); ev(4'h1, 8'h31);
        ev(4'h1, 8'h42); ev(4'h2, 8'h53);
        wait_done(4);
        drained("R6 three-byte read complete");

        // zero-length read rejected
        ex_done("R7 bad length", 2'd3);
        @(negedge clk);
        sc = cyc;
        msg_addr = 7'h33; msg_rd = 1'b1; msg_len = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(5);
        check("R7 done latency", done_cyc - sc == 1, 16'(done_cyc - sc), 16'd1);
        drained("R7 no access");

        // NACK mid-write: position held, error reported
        ex_w("R2 ien", 2'd1, 8'h0F); ex_w("R2 start", 2'd0, 8'h94);
        ex_w("R3 dte off", 2'd1, 8'h0D); ex_w("R3 addr", 2'd3, 8'h14);
        ex_w("R8 clr tack+wait", 2'd2, 8'h00);
        ex_w("R8 same byte", 2'd3, 8'hAA); ex_w("R4 stop", 2'd0, 8'h90);
        ex_w("R9 clr", 2'd2, 8'h00);
        ex_w("R9 final clr", 2'd2, 8'h00);
        ex_done("R8 no-ack code", 2'd1);
        go(7'h0A, 1'b0, 8'd1);
        ev(4'h2, 8'h00); ev(4'h5, 8'h00); ev(4'h1, 8'h00); ev(4'h1, 8'h00);
        wait_done(6);
        drained("R8 complete");

        // arbitration lost then BUSY stuck: timeout wins
        bus_busy = 1'b1;
        ex_w("R2 ien", 2'd1, 8'h0F); ex_w("R2 start", 2'd0, 8'h94);
        ex_w("R4 addr as last", 2'd3, 8'h7E); ex_w("R4 stop", 2'd0, 8'h90);
        ex_w("R8 clr al+wait", 2'd2, 8'h00);
        ex_w("R9 final clr", 2'd2, 8'h00);
        ex_done("R10 busy timeout", 2'd2);
        go(7'h3F, 1'b0, 8'd0);
        ev(4'h2, 8'h00); ev(4'h9, 8'h00); ev(4'h1, 8'h00);
        wait_done(7);
        check("R10 timeout latency", done_cyc - last_acc_cyc == (TRIES - 1) * GAP + 2,
              16'(done_cyc - last_acc_cyc), 16'((TRIES - 1) * GAP + 2));
        bus_busy = 1'b0;
        drained("R10 complete");
        check("R11 done deasserted", !done, {15'd0, done}, 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule